// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register port of an eight-input interrupt controller. It sits between a host bus and the controller's priority logic. The bus presents one address bit, a write byte, a write strobe and a read strobe. The block turns these writes into persistent control state and into short strobes for the priority logic. The current request and in-service vectors, and the poll answer produced by the priority logic, come back in as inputs so the host can read them.

Address 0 carries three kinds of command, told apart by data bits. Bit 4 set starts initialization. Bit 3 set, with bit 4 clear, is a status and mode command. Anything else is an end-of-service or rotation command. That last kind is passed on as a one-cycle strobe with its 3-bit command and level fields. Address 1 is steered by a four-state sequencer. After an initialization start, it accepts the vector base, then an optional cascade word, then an optional mode word. Only after that does it go back to loading the interrupt mask. The path through the sequencer depends on the single/cascade flag and the mode-word-needed flag that were captured at the start.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, vector base, every mode flag, the error flag and both strobes are 0, and the sequencer is ready, so the first address-1 write loads the mask.
- R2: An address-0 write with data bit 4 set clears the mask, vector base, poll, read-select, special-mask, nested and auto-EOI flags. It captures bit 1 as the single-mode flag and bit 0 as the mode-word-needed flag. It raises `init_pulse` for exactly the following cycle, and no operation strobe.
- R3: `level_err` takes data bit 3 of each initialization-start write and holds that value until the next initialization start or reset.
- R4: The first address-1 write after an initialization start loads the vector base as data AND 0xF8. The sequencer next expects the mode word in single mode with the flag set, returns to ready in single mode without it, and expects the cascade word in cascade mode.
- R5: The cascade word changes no output. It is followed by the mode word if the mode-word-needed flag is set, and otherwise by ready.
- R6: The mode word sets the nested flag from bit 4 and auto-EOI from bit 1, leaves the mask unchanged, and returns the sequencer to ready.
- R7: An address-1 write loads the mask only while the sequencer is ready; while the sequencer is not ready, the mask holds.
- R8: An address-0 write with bit 4 clear and bit 3 set sets poll when bit 2 is 1. It loads read-select from bit 0 when bit 1 is 1, and loads special-mask from bit 5 when bit 6 is 1. Otherwise each of these flags holds its value.
- R9: An address-0 write with bits 4 and 3 both clear raises `op2_strobe` for exactly the following cycle, with `op2_cmd` = data bits 7:5 and `op2_level` = data bits 2:0. No other write raises it.
- R10: Outside poll mode, `rd_data` shows the in-service vector at address 0 when read-select is 1, the request vector at address 0 when read-select is 0, and the mask at address 1.
- R11: While poll is set, `rd_data` shows `poll_in` at either address. A read strobe without a concurrent write clears poll, after which normal reads resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr0 | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| irr_in | input | 8 | Current request vector |
| isr_in | input | 8 | Current in-service vector |
| poll_in | input | 8 | Poll answer from priority logic |
| rd_data | output | 8 | Read data |
| mask_reg | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| single_mode | output | 1 | Single (non-cascaded) operation |
| auto_eoi | output | 1 | Automatic end of service |
| nested_mode | output | 1 | Special fully nested mode |
| poll_mode | output | 1 | Poll pending |
| read_isr | output | 1 | Address-0 read selects in-service vector |
| special_mask | output | 1 | Special mask mode |
| level_err | output | 1 | Unsupported level-mode request seen |
| init_pulse | output | 1 | One-cycle clear request for priority logic |
| op2_strobe | output | 1 | One-cycle operation strobe |
| op2_cmd | output | 3 | Operation command field |
| op2_level | output | 3 | Operation level field |

## Verification
The address-0 decode is driven by a table of bytes. The table covers every bit-4/bit-3 class, status commands with each enable bit alone and combined, and operation words with differing command and level fields. This separates a wrong class decode from a wrong field extraction. The sequencer is run along all four paths: cascade with and without the mode word, and single with and without it. After each path, a trailing mask write shows whether the sequencer returned to ready at the right word. Reads are taken with distinct request, in-service, mask and poll values, so that each mux choice yields a different byte.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_VEC   = 2'd1,
      ST_CASC  = 2'd2,
      ST_MODE  = 2'd3
   } init_st_t;

   // Address-0 class decode bits
   localparam int B_INIT    = 4;
   localparam int B_OP3     = 3;
   // Initialization-start fields
   localparam int B_NEED_MW = 0;
   localparam int B_SOLO    = 1;
   localparam int B_LEVEL   = 3;
   // Mode word fields
   localparam int B_AEOI    = 1;
   localparam int B_NEST    = 4;
   // Status command fields
   localparam int B_RSEL    = 0;
   localparam int B_RSEL_EN = 1;
   localparam int B_POLL    = 2;
   localparam int B_SMM     = 5;
   localparam int B_SMM_EN  = 6;

   typedef struct packed {
      logic init;
      logic op3;
      logic op2;
      logic port1;
   } wr_class_t;

endpackage

// File: rtl/pic_wr_class.sv
module pic_wr_class
   import pic_cmd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          wr_en,
   input  logic          addr0,
   input  logic [DW-1:0] wr_data,
   output wr_class_t     cls
);
   logic is_init, is_op3;

   always_comb begin
      is_init   = wr_data[B_INIT];
      is_op3    = !wr_data[B_INIT] && wr_data[B_OP3];
      cls.init  = wr_en && !addr0 && is_init;
      cls.op3   = wr_en && !addr0 && is_op3;
      cls.op2   = wr_en && !addr0 && !is_init && !is_op3;
      cls.port1 = wr_en && addr0;
   end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_cmd_pkg::*;
#(
   parameter int DW      = 8,
   parameter int VEC_LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wr_class_t     cls,
   input  logic [DW-1:0] wr_data,
   output logic          ready,
   output logic          single_mode,
   output logic [DW-1:0] vec_base,
   output logic          nested_mode,
   output logic          auto_eoi,
   output logic          level_err,
   output logic          init_pulse
);
   init_st_t      st;
   logic          need_mw;
   logic [DW-1:0] vec_keep;

   for (genvar b = 0; b < DW; b++) begin : g_vmask
      assign vec_keep[b] = (b >= VEC_LSB);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_READY;
         need_mw     <= 1'b0;
         single_mode <= 1'b0;
         vec_base    <= '0;
         nested_mode <= 1'b0;
         auto_eoi    <= 1'b0;
         level_err   <= 1'b0;
         init_pulse  <= 1'b0;
      end else begin
         init_pulse <= cls.init;
         if (cls.init) begin
            st          <= ST_VEC;
            need_mw     <= wr_data[B_NEED_MW];
            single_mode <= wr_data[B_SOLO];
            level_err   <= wr_data[B_LEVEL];
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
         end else if (cls.port1) begin
            unique case (st)
               ST_VEC: begin
                  vec_base <= wr_data & vec_keep;
                  if (single_mode) st <= need_mw ? ST_MODE : ST_READY;
                  else             st <= ST_CASC;
               end
               ST_CASC: st <= need_mw ? ST_MODE : ST_READY;
               ST_MODE: begin
                  nested_mode <= wr_data[B_NEST];
                  auto_eoi    <= wr_data[B_AEOI];
                  st          <= ST_READY;
               end
               default: st <= ST_READY;
            endcase
         end
      end
   end

   assign ready = (st == ST_READY);
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
   import pic_cmd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wr_class_t     cls,
   input  logic [DW-1:0] wr_data,
   input  logic          ready,
   input  logic          rd_en,
   output logic [DW-1:0] mask_reg,
   output logic          poll_mode,
   output logic          read_isr,
   output logic          special_mask,
   output logic          op2_strobe,
   output logic [2:0]    op2_cmd,
   output logic [2:0]    op2_level
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_reg     <= '0;
         poll_mode    <= 1'b0;
         read_isr     <= 1'b0;
         special_mask <= 1'b0;
         op2_strobe   <= 1'b0;
         op2_cmd      <= '0;
         op2_level    <= '0;
      end else begin
         op2_strobe <= cls.op2;
         if (cls.op2) begin
            op2_cmd   <= wr_data[DW-1 -: 3];
            op2_level <= wr_data[2:0];
         end
         if (cls.init) begin
            mask_reg     <= '0;
            poll_mode    <= 1'b0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
         end else begin
            if (cls.port1 && ready) mask_reg <= wr_data;
            if (cls.op3 && wr_data[B_POLL]) poll_mode <= 1'b1;
            else if (rd_en)                 poll_mode <= 1'b0;
            if (cls.op3 && wr_data[B_RSEL_EN]) read_isr     <= wr_data[B_RSEL];
            if (cls.op3 && wr_data[B_SMM_EN])  special_mask <= wr_data[B_SMM];
         end
      end
   end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
   parameter int DW = 8
) (
   input  logic          addr0,
   input  logic          poll_mode,
   input  logic          read_isr,
   input  logic [DW-1:0] irr_in,
   input  logic [DW-1:0] isr_in,
   input  logic [DW-1:0] mask_reg,
   input  logic [DW-1:0] poll_in,
   output logic [DW-1:0] rd_data
);
   always_comb begin
      if (poll_mode)     rd_data = poll_in;
      else if (addr0)    rd_data = mask_reg;
      else if (read_isr) rd_data = isr_in;
      else               rd_data = irr_in;
   end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
   import pic_cmd_pkg::*;
#(
   parameter int DW      = 8,
   parameter int VEC_LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr0,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [DW-1:0] irr_in,
   input  logic [DW-1:0] isr_in,
   input  logic [DW-1:0] poll_in,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] mask_reg,
   output logic [DW-1:0] vec_base,
   output logic          single_mode,
   output logic          auto_eoi,
   output logic          nested_mode,
   output logic          poll_mode,
   output logic          read_isr,
   output logic          special_mask,
   output logic          level_err,
   output logic          init_pulse,
   output logic          op2_strobe,
   output logic [2:0]    op2_cmd,
   output logic [2:0]    op2_level
);
   if (DW != 8) begin : g_bad_dw
      $error("pic_cmd_decoder: command fields need DW == 8");
   end
   if (VEC_LSB < 1 || VEC_LSB >= DW) begin : g_bad_vec
      $error("pic_cmd_decoder: VEC_LSB out of range");
   end

   wr_class_t cls;
   logic      ready;

   pic_wr_class #(.DW(DW)) u_class (
      .wr_en   (wr_en),
      .addr0   (addr0),
      .wr_data (wr_data),
      .cls     (cls)
   );

   pic_init_seq #(.DW(DW), .VEC_LSB(VEC_LSB)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cls         (cls),
      .wr_data     (wr_data),
      .ready       (ready),
      .single_mode (single_mode),
      .vec_base    (vec_base),
      .nested_mode (nested_mode),
      .auto_eoi    (auto_eoi),
      .level_err   (level_err),
      .init_pulse  (init_pulse)
   );

   pic_op_regs #(.DW(DW)) u_ops (
      .clk          (clk),
      .rst_n        (rst_n),
      .cls          (cls),
      .wr_data      (wr_data),
      .ready        (ready),
      .rd_en        (rd_en),
      .mask_reg     (mask_reg),
      .poll_mode    (poll_mode),
      .read_isr     (read_isr),
      .special_mask (special_mask),
      .op2_strobe   (op2_strobe),
      .op2_cmd      (op2_cmd),
      .op2_level    (op2_level)
   );

   pic_rd_mux #(.DW(DW)) u_rd (
      .addr0     (addr0),
      .poll_mode (poll_mode),
      .read_isr  (read_isr),
      .irr_in    (irr_in),
      .isr_in    (isr_in),
      .mask_reg  (mask_reg),
      .poll_in   (poll_in),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          addr0,
   input logic          wr_en,
   input logic [DW-1:0] wr_data,
   input logic          rd_en,
   input logic [DW-1:0] mask_reg,
   input logic          poll_mode,
   input logic          level_err,
   input logic          init_pulse,
   input logic          op2_strobe,
   input logic [2:0]    op2_cmd,
   input logic [2:0]    op2_level
);
   assert_init_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr0 && wr_data[4]) |=> (init_pulse && !op2_strobe));

   assert_level_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr0 && wr_data[4]) |=> (level_err == $past(wr_data[3])));

   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_reg));

   assert_op2_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op2_strobe |-> $past(wr_en && !addr0 && !wr_data[4] && !wr_data[3]));

   assert_op2_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op2_strobe |-> (op2_cmd == $past(wr_data[7:5]) && op2_level == $past(wr_data[2:0])));

   assert_poll_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_mode && rd_en && !wr_en) |=> !poll_mode);
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.DW(DW)) u_chk (.*);

// File: tb/pic_cmd_decoder_bench.sv
module pic_cmd_decoder_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr0 = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0, irr_in = '0, isr_in = '0, poll_in = '0;
   logic [7:0] rd_data, mask_reg, vec_base;
   logic       single_mode, auto_eoi, nested_mode, poll_mode, read_isr;
   logic       special_mask, level_err, init_pulse, op2_strobe;
   logic [2:0] op2_cmd, op2_level;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pic_cmd_decoder u_pic_cmd_decoder (.*);

   // {addr, data, strobe, cmd, level, poll, rsel, smask, mask}
   localparam logic [26:0] TBL [9] = '{
      {1'b0, 8'h20, 1'b1, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00},
      {1'b0, 8'h0B, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00},
      {1'b0, 8'h68, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h00},
      {1'b0, 8'hE5, 1'b1, 3'd7, 3'd5, 1'b0, 1'b1, 1'b1, 8'h00},
      {1'b0, 8'h0C, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b1, 8'h00},
      {1'b0, 8'h4A, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00},
      {1'b0, 8'h63, 1'b1, 3'd3, 3'd3, 1'b1, 1'b0, 1'b0, 8'h00},
      {1'b1, 8'h5A, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h5A},
      {1'b0, 8'hC7, 1'b1, 3'd6, 3'd7, 1'b1, 1'b0, 1'b0, 8'h5A}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr0 = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", mask_reg, 8'h00);
      chk("R1 vec", vec_base, 8'h00);
      chk("R1 flags", {single_mode, auto_eoi, nested_mode, poll_mode, read_isr, special_mask, level_err, 1'b0}, 8'h00);
      chk("R1 strobes", {6'd0, init_pulse, op2_strobe}, 8'h00);
      wr(1'b1, 8'h33);
      chk("R1 R7 mask load when ready", mask_reg, 8'h33);

      // Cascade path with mode word
      wr(1'b0, 8'h11);
      chk("R2 init pulse", {6'd0, init_pulse, op2_strobe}, 8'h02);
      chk("R2 mask cleared", mask_reg, 8'h00);
      chk("R2 single flag", {7'd0, single_mode}, 8'h00);
      @(negedge clk);
      chk("R2 pulse one cycle", {7'd0, init_pulse}, 8'h00);
      wr(1'b1, 8'h47);
      chk("R4 vector base", vec_base, 8'h40);
      wr(1'b1, 8'h04);
      chk("R5 cascade word no effect", mask_reg, 8'h00);
      chk("R5 cascade word vec", vec_base, 8'h40);
      wr(1'b1, 8'h12);
      chk("R6 nested/aeoi", {6'd0, nested_mode, auto_eoi}, 8'h03);
      chk("R6 R7 mask held", mask_reg, 8'h00);

      // Table of address-0 and mask writes
      for (int i = 0; i < 9; i++) begin
         wr(TBL[i][26], TBL[i][25:18]);
         chk($sformatf("R9 strobe row %0d", i), {7'd0, op2_strobe}, {7'd0, TBL[i][17]});
         if (TBL[i][17]) begin
            chk($sformatf("R9 cmd row %0d", i), {5'd0, op2_cmd}, {5'd0, TBL[i][16:14]});
            chk($sformatf("R9 level row %0d", i), {5'd0, op2_level}, {5'd0, TBL[i][13:11]});
         end
         chk($sformatf("R8 flags row %0d", i), {5'd0, poll_mode, read_isr, special_mask},
             {5'd0, TBL[i][10:8]});
         chk($sformatf("R7 mask row %0d", i), mask_reg, TBL[i][7:0]);
      end
      @(negedge clk);
      chk("R9 strobe one cycle", {7'd0, op2_strobe}, 8'h00);

      // Single, no mode word
      wr(1'b0, 8'h12);
      chk("R2 single set", {7'd0, single_mode}, 8'h01);
      chk("R2 flags cleared", {4'd0, nested_mode, auto_eoi, poll_mode, special_mask}, 8'h00);
      wr(1'b1, 8'h9B);
      chk("R4 vector masked", vec_base, 8'h98);
      wr(1'b1, 8'h0F);
      chk("R4 single direct to ready", mask_reg, 8'h0F);

      // Single with mode word
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h02);
      chk("R6 auto only", {6'd0, nested_mode, auto_eoi}, 8'h01);
      chk("R6 mask untouched", mask_reg, 8'h00);
      wr(1'b1, 8'h77);
      chk("R6 back to ready", mask_reg, 8'h77);

      // Cascade without mode word
      wr(1'b0, 8'h10);
      chk("R2 cascade flag", {7'd0, single_mode}, 8'h00);
      wr(1'b1, 8'h08);
      wr(1'b1, 8'hFF);
      chk("R5 cascade word ignored", mask_reg, 8'h00);
      wr(1'b1, 8'h3C);
      chk("R5 ready after cascade", mask_reg, 8'h3C);

      // Level request error
      wr(1'b0, 8'h18);
      chk("R3 level flag set", {7'd0, level_err}, 8'h01);
      wr(1'b0, 8'h0A);
      chk("R3 level flag held", {7'd0, level_err}, 8'h01);
      wr(1'b0, 8'h10);
      chk("R3 level flag cleared", {7'd0, level_err}, 8'h00);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h00);

      // Read mux
      irr_in = 8'hA1; isr_in = 8'h5C; poll_in = 8'h83;
      wr(1'b0, 8'h0A);
      addr0 = 1'b0; #1;
      chk("R10 request read", rd_data, 8'hA1);
      wr(1'b0, 8'h0B);
      addr0 = 1'b0; #1;
      chk("R10 in-service read", rd_data, 8'h5C);
      wr(1'b1, 8'hE4);
      addr0 = 1'b1; #1;
      chk("R10 mask read", rd_data, 8'hE4);

      // Poll
      wr(1'b0, 8'h0C);
      chk("R11 poll set", {7'd0, poll_mode}, 8'h01);
      addr0 = 1'b0; #1;
      chk("R11 poll data addr0", rd_data, 8'h83);
      addr0 = 1'b1; #1;
      chk("R11 poll data addr1", rd_data, 8'h83);
      @(negedge clk);
      addr0 = 1'b0; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; #1;
      chk("R11 poll cleared", {7'd0, poll_mode}, 8'h00);
      chk("R11 normal read resumes", rd_data, 8'h5C);

      // Reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mask after reset", mask_reg, 8'h00);
      chk("R1 flags after reset", {read_isr, nested_mode, auto_eoi, 5'd0}, 8'h00);
      wr(1'b1, 8'h81);
      chk("R1 ready after reset", mask_reg, 8'h81);

      finish_run();
   end
endmodule